// File: doc/BRIEF.md
# Programmable Compare Timer Channel

This block is one 16-bit timer channel with a three-register software interface. Software loads a compare value, can preset the up counter, and writes a control/status word. The counter advances on a prescaled time base. That time base is built from one of two single-cycle rate strobes, both synchronous to the core clock. Every count tick is checked against the compare value. A match sets sticky status flags, and in one compare mode it also produces a one-cycle interrupt pulse. After a match the counter restarts from zero, so the channel gives a periodic event with a period of compare+1 ticks.

The low twelve bits of the control word hold the operating configuration: prescale exponent, source select and compare mode. Software may set them once. The first write to the control register captures them and raises a read-only lock flag, and from then on only a reset can change them. The run bit and the two event flags stay under software control after the lock. The event flags are cleared by writing 1 to them.

Top module: `tmr_channel`

## Requirements
- R1: After reset the compare register, the counter and the whole control word (lock flag included) read 0, and irq_o is low.
- R2: The compare value is at offset 0xA, the counter at 0xC and the control word at 0xE. Reads and writes at any other offset read 0 and change nothing.
- R3: Control word layout: bit 15 run, bit 14 compare-2 event, bit 13 compare-1 event, bit 12 lock (read-only), bits 11:0 configuration. The first control write captures bits 11:0 and sets bit 12. Later writes leave bits 11:0 unchanged until reset, while bit 15 still follows every write.
- R4: Configuration bits 3:0 hold an exponent s. The counter advances once per 2^s strobes of the selected source.
- R5: Configuration bit 4 selects fast_stb_i when 1 and slow_stb_i when 0. Strobes on the source that is not selected have no effect.
- R6: The counter changes only on a count tick while bit 15 is 1, or when software writes the counter. A counter write loads the written value directly.
- R7: Configuration bits 9:8 set the compare-2 mode: 00 off, 01 counter equal to compare, 10 counter greater than or equal to compare, 11 greater than or equal with interrupt. Bit 14 is set when a count tick lands the counter on a value that meets the mode.
- R8: On a count tick, a counter that already meets the compare-2 mode goes to 0. In every mode a tick at 0xFFFF goes to 0.
- R9: Bit 13 is set when a count tick lands the counter exactly on the compare value, whatever the compare-2 mode.
- R10: Writing 1 to bit 14 or bit 13 clears that flag. Writing 0 leaves it unchanged, and a set flag stays set until it is cleared.
- R11: In mode 11, irq_o is high for exactly one clock, in the cycle after bit 14 goes from 0 to 1. A flag that is already set gives no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_stb_i | input | 1 | Fast-rate single-cycle strobe |
| slow_stb_i | input | 1 | Slow-rate single-cycle strobe |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | One-cycle compare-2 interrupt pulse |

## Verification
The bench writes a second, different configuration after the first one. A design that does not hold the lock would read back the new scale and mode. It loads the counter above the compare value in equal mode: a design that mixes up the modes wraps to 0 where it should count on to 6. It clears one flag with write-1 and checks that the other flag survives. It also re-arms the event to look for a second interrupt pulse, which a design that checks the flag level instead of its rising edge would miss or repeat. It runs a prescale of 8 on the slow source with fast strobes mixed in, and it ticks through the 0xFFFF wrap with the compare-2 mode off. An off-by-one prescaler, a design that leaks the unselected source, or one that sets the compare-2 flag in off mode would each show a different counter or flag value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W   = 16;
    localparam int ADDR_W  = 4;
    localparam int SCALE_W = 4;
    localparam int PRE_W   = (1 << SCALE_W) - 1;
    localparam int CFG_W   = 12;

    localparam logic [ADDR_W-1:0] OFS_CMP = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_CNT = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_CTL = 4'hE;

    localparam int B_RUN  = 15;
    localparam int B_EV2  = 14;
    localparam int B_EV1  = 13;
    localparam int B_LOCK = 12;

    typedef enum logic [1:0] {
        CMP_OFF    = 2'b00,
        CMP_EQ     = 2'b01,
        CMP_GE     = 2'b10,
        CMP_GE_IRQ = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic                stop_en;
        logic                spare_hi;
        cmp_mode_e           c2_mode;
        logic [2:0]          spare_lo;
        logic                clk_fast;
        logic [SCALE_W-1:0]  scale;
    } cfg_t;

    typedef struct packed {
        logic             wr_cmp;
        logic             wr_cnt;
        logic             wr_ctl;
        logic [REG_W-1:0] data;
    } bus_wr_t;

    function automatic logic cmp_meets(cmp_mode_e m, logic [REG_W-1:0] v,
                                       logic [REG_W-1:0] c);
        case (m)
            CMP_EQ:                 return v == c;
            CMP_GE, CMP_GE_IRQ:     return v >= c;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic [PRE_W-1:0] pre_mask(logic [SCALE_W-1:0] s);
        logic [PRE_W:0] m;
        m = ({{PRE_W{1'b0}}, 1'b1} << s) - 1'b1;
        return m[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output bus_wr_t              bus_wr,
    output logic [REG_W-1:0]     cmp_val,
    output cfg_t                 cfg,
    output logic                 locked,
    output logic                 run,
    output logic                 clr_ev2,
    output logic                 clr_ev1
);

    always_comb begin
        bus_wr.data   = wdata;
        bus_wr.wr_cmp = wr_en && (addr == OFS_CMP);
        bus_wr.wr_cnt = wr_en && (addr == OFS_CNT);
        bus_wr.wr_ctl = wr_en && (addr == OFS_CTL);
    end

    assign clr_ev2 = bus_wr.wr_ctl && wdata[B_EV2];
    assign clr_ev1 = bus_wr.wr_ctl && wdata[B_EV1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
            cfg     <= '0;
            locked  <= 1'b0;
            run     <= 1'b0;
        end else begin
            if (bus_wr.wr_cmp) begin
                cmp_val <= wdata;
            end
            if (bus_wr.wr_ctl) begin
                run <= wdata[B_RUN];
                if (!locked) begin
                    cfg    <= cfg_t'(wdata[CFG_W-1:0]);
                    locked <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               sel_fast,
    input  logic [SCALE_W-1:0] scale,
    input  logic               fast_stb,
    input  logic               slow_stb,
    output logic               tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;
    logic             src;

    assign src  = sel_fast ? fast_stb : slow_stb;
    assign mask = pre_mask(scale);
    assign tick = run && src && (pre_cnt == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
        end else if (src) begin
            pre_cnt <= (pre_cnt == mask) ? '0 : pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  bus_wr_t          bus_wr,
    input  logic [REG_W-1:0] cmp_val,
    input  cmp_mode_e        mode,
    input  logic             clr_ev2,
    input  logic             clr_ev1,
    output logic [REG_W-1:0] count,
    output logic             ev2,
    output logic             ev1,
    output logic             irq
);

    logic [REG_W-1:0] nxt;
    logic             hit_now;
    logic             adv;
    logic             ev2_q;

    assign hit_now = cmp_meets(mode, count, cmp_val);
    assign nxt     = hit_now ? '0 : count + 1'b1;
    assign adv     = tick && !bus_wr.wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ev2   <= 1'b0;
            ev1   <= 1'b0;
            ev2_q <= 1'b0;
        end else begin
            if (bus_wr.wr_cnt) begin
                count <= bus_wr.data;
            end else if (tick) begin
                count <= nxt;
            end
            ev2   <= (ev2 && !clr_ev2) || (adv && cmp_meets(mode, nxt, cmp_val));
            ev1   <= (ev1 && !clr_ev1) || (adv && (nxt == cmp_val));
            ev2_q <= ev2;
        end
    end

    assign irq = ev2 && !ev2_q && (mode == CMP_GE_IRQ);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_stb_i,
    input  logic              slow_stb_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);

    bus_wr_t          bus_wr;
    logic [REG_W-1:0] cmp_val;
    cfg_t             cfg;
    logic             locked;
    logic             run;
    logic             clr_ev2;
    logic             clr_ev1;
    logic             tick;
    logic [REG_W-1:0] count;
    logic             ev2;
    logic             ev1;

    tmr_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .bus_wr  (bus_wr),
        .cmp_val (cmp_val),
        .cfg     (cfg),
        .locked  (locked),
        .run     (run),
        .clr_ev2 (clr_ev2),
        .clr_ev1 (clr_ev1)
    );

    tmr_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sel_fast (cfg.clk_fast),
        .scale    (cfg.scale),
        .fast_stb (fast_stb_i),
        .slow_stb (slow_stb_i),
        .tick     (tick)
    );

    tmr_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .bus_wr  (bus_wr),
        .cmp_val (cmp_val),
        .mode    (cfg.c2_mode),
        .clr_ev2 (clr_ev2),
        .clr_ev1 (clr_ev1),
        .count   (count),
        .ev2     (ev2),
        .ev1     (ev1),
        .irq     (irq_o)
    );

    always_comb begin
        case (addr_i)
            OFS_CMP: rdata_o = cmp_val;
            OFS_CNT: rdata_o = count;
            OFS_CTL: rdata_o = {run, ev2, ev1, locked, cfg};
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             ev2,
    input logic             ev2_clr,
    input logic             locked,
    input cfg_t             cfg,
    input logic             run,
    input logic [REG_W-1:0] count,
    input logic             cnt_wr,
    input logic             tick
);

    // R3: the lock flag never drops outside reset
    p_lock_held_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R3: locked configuration stays frozen
    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cfg));

    // R6: stopped and not written means the counter holds
    p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(count));

    // R8: a tick at all-ones always lands on zero
    p_wrap_top_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count == 16'hFFFF) |=> (count == '0));

    // R10: a set flag survives unless cleared
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ev2 && !ev2_clr) |=> ev2);

    // R11: interrupt lasts one cycle
    p_irq_single_r11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R11: interrupt only with the flag set in interrupt mode
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev2 && cfg.c2_mode == CMP_GE_IRQ));

endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq_o),
    .ev2     (ev2),
    .ev2_clr (clr_ev2),
    .locked  (locked),
    .cfg     (cfg),
    .run     (run),
    .count   (count),
    .cnt_wr  (bus_wr.wr_cnt),
    .tick    (tick)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fast_stb = 1'b0;
    logic        slow_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk        (clk),
        .rst        (rst),
        .fast_stb_i (fast_stb),
        .slow_stb_i (slow_stb),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  a;
        logic [15:0] d;
    } vec_t;

    // register map and lock walk (R2, R3); reads compare d
    localparam vec_t VECS [12] = '{
        '{1'b1, 4'hA, 16'h1234},
        '{1'b0, 4'hA, 16'h1234},
        '{1'b1, 4'hC, 16'h00FF},
        '{1'b0, 4'hC, 16'h00FF},
        '{1'b0, 4'hE, 16'h0000},
        '{1'b1, 4'h2, 16'hBEEF},
        '{1'b0, 4'h2, 16'h0000},
        '{1'b1, 4'hE, 16'h0310},
        '{1'b0, 4'hE, 16'h1310},
        '{1'b1, 4'hE, 16'h0205},
        '{1'b0, 4'hE, 16'h1310},
        '{1'b0, 4'hA, 16'h1234}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic strobe(input bit fast, input int n);
        repeat (n) begin
            @(negedge clk);
            if (fast) fast_stb = 1'b1; else slow_stb = 1'b1;
            @(negedge clk);
            fast_stb = 1'b0; slow_stb = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [15:0] r;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(4'hA, r); check("R1 cmp", r, 16'h0);
        bus_read(4'hC, r); check("R1 cnt", r, 16'h0);
        bus_read(4'hE, r); check("R1 ctl", r, 16'h0);
        check("R1 irq", irq, 1'b0);

        // R2 and R3: table walk
        for (int i = 0; i < 12; i++) begin
            if (VECS[i].is_wr) bus_write(VECS[i].a, VECS[i].d);
            else begin
                bus_read(VECS[i].a, r);
                check($sformatf("R2/R3 table step %0d", i), r, VECS[i].d);
            end
        end

        // cfg now: mode 11, fast source, scale 0
        bus_write(4'hA, 16'h0003);
        bus_write(4'hC, 16'h0000);
        bus_write(4'hE, 16'h8000);
        bus_read(4'hE, r); check("R3 run writable after lock", r, 16'h9310);
        strobe(1, 2);
        bus_read(4'hC, r); check("R4 scale0 count", r, 16'h0002);
        bus_read(4'hE, r); check("R7 no event yet", r, 16'h9310);
        strobe(1, 1);
        bus_read(4'hC, r); check("R6 count at compare", r, 16'h0003);
        bus_read(4'hE, r); check("R7 R9 flags set", r, 16'hF310);
        check("R11 first pulse", irq_cnt, 1);
        strobe(0, 3);
        bus_read(4'hC, r); check("R5 slow ignored", r, 16'h0003);
        strobe(1, 1);
        bus_read(4'hC, r); check("R8 wrap after match", r, 16'h0000);
        check("R11 sticky flag no repulse", irq_cnt, 1);
        bus_write(4'hE, 16'hC000);
        bus_read(4'hE, r); check("R10 clear ev2 only", r, 16'hB310);
        bus_write(4'hE, 16'h8000);
        bus_read(4'hE, r); check("R10 zero no effect", r, 16'hB310);
        strobe(1, 3);
        bus_read(4'hE, r); check("R7 event again", r, 16'hF310);
        check("R11 second pulse", irq_cnt, 2);
        bus_write(4'hE, 16'h6000);
        bus_read(4'hE, r); check("R10 clear both and stop", r, 16'h1310);
        strobe(1, 2);
        bus_read(4'hC, r); check("R6 stopped holds", r, 16'h0003);

        // prescale 8 on slow source, GE without interrupt
        do_reset();
        bus_read(4'hE, r); check("R1 ctl after second reset", r, 16'h0);
        base = irq_cnt;
        bus_write(4'hA, 16'h0002);
        bus_write(4'hE, 16'h8203);
        strobe(0, 7);
        bus_read(4'hC, r); check("R4 below divide", r, 16'h0000);
        strobe(0, 1);
        bus_read(4'hC, r); check("R4 divide by 8", r, 16'h0001);
        strobe(1, 4);
        bus_read(4'hC, r); check("R5 fast ignored", r, 16'h0001);
        strobe(0, 8);
        bus_read(4'hC, r); check("R4 second tick", r, 16'h0002);
        bus_read(4'hE, r); check("R7 GE flag", r, 16'hF203);
        check("R11 no irq in mode 10", irq_cnt, base);

        // equal mode with counter loaded above compare
        do_reset();
        bus_write(4'hA, 16'h0002);
        bus_write(4'hC, 16'h0005);
        bus_write(4'hE, 16'h8110);
        strobe(1, 1);
        bus_read(4'hC, r); check("R7 equal mode counts on", r, 16'h0006);
        bus_read(4'hE, r); check("R7 equal mode no flag", r, 16'h9110);

        // mode off: overflow wrap and compare-1 flag
        do_reset();
        bus_write(4'hA, 16'h0005);
        bus_write(4'hC, 16'hFFFF);
        bus_write(4'hE, 16'h8010);
        strobe(1, 1);
        bus_read(4'hC, r); check("R8 overflow wrap", r, 16'h0000);
        bus_read(4'hE, r); check("R8 no flags at wrap", r, 16'h9010);
        strobe(1, 5);
        bus_read(4'hE, r); check("R9 cmp1 flag in off mode", r, 16'hB010);
        strobe(1, 1);
        bus_read(4'hC, r); check("R7 off mode no wrap", r, 16'h0006);

        summary();
    end

endmodule